// File: doc/BRIEF.md
# Register Scoreboard with Operand Bypass Selection

This block sits beside the decode stage of an in-order integer pipeline. It keeps one pending flag per architectural integer register. The flag records that an instruction already issued will still write that register. For each of the two source operands of the instruction in decode, it chooses where the value comes from. The choices are the register file, the execute-stage forwarding port, the memory-stage forwarding port or a hardwired zero. If no source can supply a correct value yet, it raises a stall.

A flag is set one cycle after decode issues an instruction that writes a non-zero destination. It is cleared by the synchronous write-back commit of that register. A flush clears the flags given by a mask of entries whose writers were squashed. Each forwarding port reports two things separately: whether its destination index is known and whether its result data is ready. A load whose destination matches but whose data is still outstanding therefore holds decode back rather than forwarding stale data. The register file is read asynchronously outside this block, and its read data comes back in through the rs*_rf_data inputs.

Top module: `reg_scoreboard_byp`

## Requirements
- R1: When iss_valid and iss_rd_we are high and iss_rd is non-zero at a rising edge, that register is pending from the next cycle on.
- R2: When wb_we is high with a non-zero wb_rd at a rising edge, that register is no longer pending from the next cycle on, unless R9 applies.
- R3: An enabled operand with a non-zero index whose register is not pending has select 0 (register file), raises its read request and outputs the register-file data.
- R4: An operand whose read-enable is low or whose index is 0 has select 3 (zero), outputs zero, does not request a read and never stalls, whatever the forwarding ports carry; register 0 is never pending.
- R5: A pending operand whose index matches the execute port address, with that port's address-valid and data-valid both high, has select 1 and outputs the execute port data.
- R6: A pending operand that matches the execute port address while that port's data-valid is low has select 4 (wait) and stalls, even when the memory port holds ready data for the same register.
- R7: A pending operand with no execute match that matches the memory port address has select 2 and outputs the memory port data if that port's data-valid is high; otherwise it has select 4 and stalls.
- R8: A pending operand that matches neither port has select 4 and stalls; a waiting operand outputs zero.
- R9: If the same register is both issued and committed in one cycle, it stays pending.
- R10: When flush_valid is high at a rising edge, every register whose bit in flush_mask is set stops being pending, except a register issued in the same cycle, which becomes pending.
- R11: stall is high exactly when at least one operand has select 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | Decode issues an instruction this cycle |
| iss_rd_we | input | 1 | Issued instruction writes a destination |
| iss_rd | input | IDXW | Destination index of issued instruction |
| wb_we | input | 1 | Write-back commit enable |
| wb_rd | input | IDXW | Committed destination index |
| flush_valid | input | 1 | Squash pending flags |
| flush_mask | input | NREG | Registers whose writers were squashed |
| rs1_re | input | 1 | Source 1 read-enable |
| rs1_idx | input | IDXW | Source 1 index |
| rs1_rf_data | input | XLEN | Register-file read data for source 1 |
| rs2_re | input | 1 | Source 2 read-enable |
| rs2_idx | input | IDXW | Source 2 index |
| rs2_rf_data | input | XLEN | Register-file read data for source 2 |
| ex_addr_vld | input | 1 | Execute port address valid |
| ex_data_vld | input | 1 | Execute port data valid |
| ex_addr | input | IDXW | Execute port destination index |
| ex_data | input | XLEN | Execute port result |
| ma_addr_vld | input | 1 | Memory port address valid |
| ma_data_vld | input | 1 | Memory port data valid |
| ma_addr | input | IDXW | Memory port destination index |
| ma_data | input | XLEN | Memory port result |
| rs1_rd_req | output | 1 | Source 1 register-file read request |
| rs1_sel | output | 3 | Source 1 select (0 RF, 1 EX, 2 MA, 3 zero, 4 wait) |
| rs1_data | output | XLEN | Source 1 operand value |
| rs2_rd_req | output | 1 | Source 2 register-file read request |
| rs2_sel | output | 3 | Source 2 select, same encoding |
| rs2_data | output | XLEN | Source 2 operand value |
| stall | output | 1 | Decode must hold |

## Verification
The assertions take for granted that the forwarding ports, the issue and the commit follow the block's rules. The properties about selects and data depend only on those combinational relations, and the flag properties only on single-cycle updates, so any input sequence is legal. The random stimulus draws register indices mostly from a small set so that forwarding matches, same-cycle issue and commit, and flushes of live flags happen often. It also lets data-valid drop while address-valid is high, which exercises the wait cases. Directed steps then set up each precedence case explicitly.

// File: rtl/sb_pkg.sv
// Package: shared types for the register scoreboard.
// Assumes: select codes are visible at the top ports and must stay stable.
package sb_pkg;
    typedef enum logic [2:0] {
        SRC_RF   = 3'd0,
        SRC_EX   = 3'd1,
        SRC_MA   = 3'd2,
        SRC_ZERO = 3'd3,
        SRC_WAIT = 3'd4
    } src_sel_e;
endpackage

// File: rtl/sb_pending_table.sv
// Module: one pending flag per register.
// Set on issue, cleared on commit or flush; set wins over any clear.
// Assumes: entry 0 has no storage and always reads as not pending.
module sb_pending_table #(
    parameter  int NREG = 32,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [IDXW-1:0] set_idx,
    input  logic            clr_en,
    input  logic [IDXW-1:0] clr_idx,
    input  logic            flush_en,
    input  logic [NREG-1:0] flush_mask,
    output logic [NREG-1:0] pend_q
);
    for (genvar i = 0; i < NREG; i++) begin : g_ent
        if (i == 0) begin : g_zero
            // Register 0 is hardwired: never pending.
            assign pend_q[i] = 1'b0;
        end else begin : g_flag
            logic hit_set;
            logic hit_clr;
            // Decode this entry's set and clear requests.
            always_comb begin
                hit_set = set_en && (set_idx == IDXW'(i));
                hit_clr = (clr_en && (clr_idx == IDXW'(i))) ||
                          (flush_en && flush_mask[i]);
            end
            // Update the flag; a same-cycle set overrides a clear.
            always_ff @(posedge clk) begin
                if (!rst_n)       pend_q[i] <= 1'b0;
                else if (hit_set) pend_q[i] <= 1'b1;
                else if (hit_clr) pend_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sb_port_match.sv
// Module: compares one forwarding port with one source index.
// Assumes: data-valid has meaning only while address-valid is high.
module sb_port_match #(
    parameter int IDXW = 5
) (
    input  logic            addr_vld,
    input  logic            data_vld,
    input  logic [IDXW-1:0] addr,
    input  logic [IDXW-1:0] idx,
    output logic            hit,
    output logic            rdy
);
    // Address match and data readiness for this port.
    always_comb begin
        hit = addr_vld && (addr == idx);
        rdy = hit && data_vld;
    end
endmodule

// File: rtl/sb_operand_sel.sv
// Module: chooses the value source for one source operand.
// Priority: zero, register file, execute port, memory port, wait.
// Assumes: the execute port holds the younger writer of any register.
module sb_operand_sel
    import sb_pkg::*;
#(
    parameter int IDXW = 5,
    parameter int XLEN = 64
) (
    input  logic            re,
    input  logic [IDXW-1:0] idx,
    input  logic            pend,
    input  logic            ex_hit,
    input  logic            ex_rdy,
    input  logic            ma_hit,
    input  logic            ma_rdy,
    input  logic [XLEN-1:0] ex_data,
    input  logic [XLEN-1:0] ma_data,
    input  logic [XLEN-1:0] rf_data,
    output logic [2:0]      sel,
    output logic [XLEN-1:0] data,
    output logic            rd_req,
    output logic            stall
);
    src_sel_e src;

    // Select the source in priority order.
    always_comb begin
        src    = SRC_ZERO;
        data   = '0;
        rd_req = 1'b0;
        stall  = 1'b0;
        if (re && (idx != '0)) begin
            if (!pend) begin
                src    = SRC_RF;
                data   = rf_data;
                rd_req = 1'b1;
            end else if (ex_hit) begin
                if (ex_rdy) begin
                    src  = SRC_EX;
                    data = ex_data;
                end else begin
                    src   = SRC_WAIT;
                    stall = 1'b1;
                end
            end else if (ma_hit) begin
                if (ma_rdy) begin
                    src  = SRC_MA;
                    data = ma_data;
                end else begin
                    src   = SRC_WAIT;
                    stall = 1'b1;
                end
            end else begin
                src   = SRC_WAIT;
                stall = 1'b1;
            end
        end
    end

    // Present the select code at the port.
    assign sel = src;
endmodule

// File: rtl/reg_scoreboard_byp.sv
// Module: register scoreboard with per-operand bypass selection.
// Tracks pending writers and picks RF, forwarded or zero data, or stalls.
// Assumes: the commit port writes the register file at the same edge.
module reg_scoreboard_byp
    import sb_pkg::*;
#(
    parameter  int NREG = 32,
    parameter  int XLEN = 64,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iss_valid,
    input  logic            iss_rd_we,
    input  logic [IDXW-1:0] iss_rd,
    input  logic            wb_we,
    input  logic [IDXW-1:0] wb_rd,
    input  logic            flush_valid,
    input  logic [NREG-1:0] flush_mask,
    input  logic            rs1_re,
    input  logic [IDXW-1:0] rs1_idx,
    input  logic [XLEN-1:0] rs1_rf_data,
    input  logic            rs2_re,
    input  logic [IDXW-1:0] rs2_idx,
    input  logic [XLEN-1:0] rs2_rf_data,
    input  logic            ex_addr_vld,
    input  logic            ex_data_vld,
    input  logic [IDXW-1:0] ex_addr,
    input  logic [XLEN-1:0] ex_data,
    input  logic            ma_addr_vld,
    input  logic            ma_data_vld,
    input  logic [IDXW-1:0] ma_addr,
    input  logic [XLEN-1:0] ma_data,
    output logic            rs1_rd_req,
    output logic [2:0]      rs1_sel,
    output logic [XLEN-1:0] rs1_data,
    output logic            rs2_rd_req,
    output logic [2:0]      rs2_sel,
    output logic [XLEN-1:0] rs2_data,
    output logic            stall
);
    localparam int NSRC = 2;

    logic [NREG-1:0] pend_q;
    logic            set_en;
    logic            clr_en;

    logic [NSRC-1:0] op_re;
    logic [IDXW-1:0] op_idx  [NSRC];
    logic [XLEN-1:0] op_rf   [NSRC];
    logic [XLEN-1:0] op_data [NSRC];
    logic [2:0]      op_sel  [NSRC];
    logic [NSRC-1:0] op_pend;
    logic [NSRC-1:0] op_req;
    logic [NSRC-1:0] op_stall;
    logic [NSRC-1:0] ex_hit, ex_rdy, ma_hit, ma_rdy;

    // Qualify issue and commit; register 0 never changes state.
    always_comb begin
        set_en = iss_valid && iss_rd_we && (iss_rd != '0);
        clr_en = wb_we && (wb_rd != '0);
    end

    sb_pending_table #(.NREG(NREG)) u_tab (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (set_en),
        .set_idx    (iss_rd),
        .clr_en     (clr_en),
        .clr_idx    (wb_rd),
        .flush_en   (flush_valid),
        .flush_mask (flush_mask),
        .pend_q     (pend_q)
    );

    // Gather the operand ports into arrays.
    always_comb begin
        op_re     = {rs2_re, rs1_re};
        op_idx[0] = rs1_idx;
        op_idx[1] = rs2_idx;
        op_rf[0]  = rs1_rf_data;
        op_rf[1]  = rs2_rf_data;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_op
        assign op_pend[g] = pend_q[op_idx[g]];

        sb_port_match #(.IDXW(IDXW)) u_ex (
            .addr_vld (ex_addr_vld),
            .data_vld (ex_data_vld),
            .addr     (ex_addr),
            .idx      (op_idx[g]),
            .hit      (ex_hit[g]),
            .rdy      (ex_rdy[g])
        );

        sb_port_match #(.IDXW(IDXW)) u_ma (
            .addr_vld (ma_addr_vld),
            .data_vld (ma_data_vld),
            .addr     (ma_addr),
            .idx      (op_idx[g]),
            .hit      (ma_hit[g]),
            .rdy      (ma_rdy[g])
        );

        sb_operand_sel #(.IDXW(IDXW), .XLEN(XLEN)) u_sel (
            .re      (op_re[g]),
            .idx     (op_idx[g]),
            .pend    (op_pend[g]),
            .ex_hit  (ex_hit[g]),
            .ex_rdy  (ex_rdy[g]),
            .ma_hit  (ma_hit[g]),
            .ma_rdy  (ma_rdy[g]),
            .ex_data (ex_data),
            .ma_data (ma_data),
            .rf_data (op_rf[g]),
            .sel     (op_sel[g]),
            .data    (op_data[g]),
            .rd_req  (op_req[g]),
            .stall   (op_stall[g])
        );
    end

    // Drive the operand outputs and the combined stall.
    always_comb begin
        rs1_rd_req = op_req[0];
        rs1_sel    = op_sel[0];
        rs1_data   = op_data[0];
        rs2_rd_req = op_req[1];
        rs2_sel    = op_sel[1];
        rs2_data   = op_data[1];
        stall      = |op_stall;
    end
endmodule

// File: rtl/sb_checker.sv
// Module: temporal and relational checks for reg_scoreboard_byp.
// Assumes: bound to every instance of the top module.
module sb_checker #(
    parameter  int NREG = 32,
    parameter  int XLEN = 64,
    localparam int IDXW = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            iss_valid,
    input logic            iss_rd_we,
    input logic [IDXW-1:0] iss_rd,
    input logic            wb_we,
    input logic [IDXW-1:0] wb_rd,
    input logic            rs1_re,
    input logic [IDXW-1:0] rs1_idx,
    input logic [XLEN-1:0] rs1_rf_data,
    input logic            ex_data_vld,
    input logic [XLEN-1:0] ex_data,
    input logic            ma_data_vld,
    input logic [XLEN-1:0] ma_data,
    input logic            rs1_rd_req,
    input logic [2:0]      rs1_sel,
    input logic [XLEN-1:0] rs1_data,
    input logic [2:0]      rs2_sel,
    input logic            stall,
    input logic [NREG-1:0] pend_q
);
    p_issue_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_rd_we && iss_rd != '0) |=> pend_q[$past(iss_rd)]);

    p_commit_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we && wb_rd != '0 && !(iss_valid && iss_rd_we && iss_rd == wb_rd))
        |=> !pend_q[$past(wb_rd)]);

    p_rf_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rs1_rd_req |-> (!pend_q[rs1_idx] && rs1_data == rs1_rf_data));

    p_zero_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rs1_re || rs1_idx == '0) |-> (rs1_sel == 3'd3 && rs1_data == '0 && !rs1_rd_req));

    p_no_pend_x0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0]);

    p_ex_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_sel == 3'd1) |-> (ex_data_vld && rs1_data == ex_data));

    p_ma_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_sel == 3'd2) |-> (ma_data_vld && rs1_data == ma_data));

    p_wait_stalls_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_sel == 3'd4 || rs2_sel == 3'd4) |-> stall);

    p_stall_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (rs1_sel == 3'd4 || rs2_sel == 3'd4));

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_rd_we && iss_rd != '0 && wb_we && wb_rd == iss_rd)
        |=> pend_q[$past(wb_rd)]);
endmodule

bind reg_scoreboard_byp sb_checker #(.NREG(NREG), .XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .iss_valid   (iss_valid),
    .iss_rd_we   (iss_rd_we),
    .iss_rd      (iss_rd),
    .wb_we       (wb_we),
    .wb_rd       (wb_rd),
    .rs1_re      (rs1_re),
    .rs1_idx     (rs1_idx),
    .rs1_rf_data (rs1_rf_data),
    .ex_data_vld (ex_data_vld),
    .ex_data     (ex_data),
    .ma_data_vld (ma_data_vld),
    .ma_data     (ma_data),
    .rs1_rd_req  (rs1_rd_req),
    .rs1_sel     (rs1_sel),
    .rs1_data    (rs1_data),
    .rs2_sel     (rs2_sel),
    .stall       (stall),
    .pend_q      (pend_q)
);

// File: tb/sim_reg_scoreboard_byp.sv
// Bench: random and directed stimulus against a bench-side model.
module sim_reg_scoreboard_byp;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 32;
    localparam int XLEN = 64;
    localparam int IDXW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            iss_valid = 0, iss_rd_we = 0, wb_we = 0, flush_valid = 0;
    logic [IDXW-1:0] iss_rd = 0, wb_rd = 0, rs1_idx = 0, rs2_idx = 0, ex_addr = 0, ma_addr = 0;
    logic [NREG-1:0] flush_mask = 0;
    logic            rs1_re = 0, rs2_re = 0;
    logic [XLEN-1:0] rs1_rf_data = 0, rs2_rf_data = 0, ex_data = 0, ma_data = 0;
    logic            ex_addr_vld = 0, ex_data_vld = 0, ma_addr_vld = 0, ma_data_vld = 0;
    logic            rs1_rd_req, rs2_rd_req, stall;
    logic [2:0]      rs1_sel, rs2_sel;
    logic [XLEN-1:0] rs1_data, rs2_data;

    int checks = 0;
    int failures = 0;
    logic [NREG-1:0] mpend = '0;

    reg_scoreboard_byp #(.NREG(NREG), .XLEN(XLEN)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected select, data, request and requirement tag for one operand.
    task automatic ref_op(input logic re, input logic [IDXW-1:0] idx, input logic [XLEN-1:0] rf,
                          output logic [2:0] sel, output logic [XLEN-1:0] d,
                          output logic req, output string tag);
        sel = 3'd3; d = '0; req = 1'b0; tag = "R4";
        if (re && idx != 0) begin
            if (!mpend[idx]) begin sel = 3'd0; d = rf; req = 1'b1; tag = "R3"; end
            else if (ex_addr_vld && ex_addr == idx) begin
                if (ex_data_vld) begin sel = 3'd1; d = ex_data; tag = "R5"; end
                else begin sel = 3'd4; tag = "R6"; end
            end else if (ma_addr_vld && ma_addr == idx) begin
                sel = ma_data_vld ? 3'd2 : 3'd4; d = ma_data_vld ? ma_data : '0; tag = "R7";
            end else begin sel = 3'd4; tag = "R8"; end
        end
    endtask

    task automatic compare_all();
        logic [2:0] s1, s2; logic [XLEN-1:0] d1, d2; logic q1, q2; string t1, t2;
        ref_op(rs1_re, rs1_idx, rs1_rf_data, s1, d1, q1, t1);
        ref_op(rs2_re, rs2_idx, rs2_rf_data, s2, d2, q2, t2);
        check({t1, " rs1 sel"}, 64'(rs1_sel), 64'(s1));
        check({t1, " rs1 data"}, rs1_data, d1);
        check({t1, " rs1 req"}, 64'(rs1_rd_req), 64'(q1));
        check({t2, " rs2 sel"}, 64'(rs2_sel), 64'(s2));
        check({t2, " rs2 data"}, rs2_data, d2);
        check({t2, " rs2 req"}, 64'(rs2_rd_req), 64'(q2));
        check("R11 stall", 64'(stall), 64'((s1 == 3'd4) || (s2 == 3'd4)));
    endtask

    // Apply one clock edge to the model: clears first, then the set (R9, R10).
    task automatic model_edge();
        for (int i = 1; i < NREG; i++) begin
            if (flush_valid && flush_mask[i]) mpend[i] = 1'b0;
            if (wb_we && wb_rd == IDXW'(i)) mpend[i] = 1'b0;
            if (iss_valid && iss_rd_we && iss_rd == IDXW'(i)) mpend[i] = 1'b1;
        end
        if (!rst_n) mpend = '0;
    endtask

    task automatic step();
        #(CLK_PERIOD/4);
        if (rst_n) compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        iss_valid = 0; iss_rd_we = 0; wb_we = 0; flush_valid = 0; flush_mask = '0;
        ex_addr_vld = 0; ex_data_vld = 0; ma_addr_vld = 0; ma_data_vld = 0;
        rs1_re = 0; rs2_re = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state: nothing pending, source reads the register file (R3).
        rs1_re = 1; rs1_idx = 3; rs1_rf_data = 64'h33;
        #(CLK_PERIOD/4);
        check("R3 reset sel", 64'(rs1_sel), 64'd0);
        check("R11 reset stall", 64'(stall), 64'd0);
        step();

        // R1: issue x5, next cycle it is pending and waits (R8).
        idle(); iss_valid = 1; iss_rd_we = 1; iss_rd = 5; step();
        idle(); rs1_re = 1; rs1_idx = 5;
        #(CLK_PERIOD/4); check("R1 pending after issue", 64'(rs1_sel), 64'd4);
        step();
        // R5: execute port forwards.
        idle(); rs1_re = 1; rs1_idx = 5; ex_addr_vld = 1; ex_data_vld = 1; ex_addr = 5; ex_data = 64'hE5;
        ma_addr_vld = 1; ma_data_vld = 1; ma_addr = 5; ma_data = 64'hA5;
        #(CLK_PERIOD/4); check("R5 ex forward", rs1_data, 64'hE5);
        step();
        // R6: execute match without data blocks the memory port.
        ex_data_vld = 0;
        #(CLK_PERIOD/4); check("R6 load wait", 64'(stall), 64'd1);
        step();
        // R7: memory port forwards when execute does not match.
        ex_addr = 9;
        #(CLK_PERIOD/4); check("R7 ma forward", rs1_data, 64'hA5);
        step();
        // R9: issue and commit x5 together, stays pending.
        idle(); iss_valid = 1; iss_rd_we = 1; iss_rd = 5; wb_we = 1; wb_rd = 5; step();
        idle(); rs2_re = 1; rs2_idx = 5;
        #(CLK_PERIOD/4); check("R9 set wins", 64'(rs2_sel), 64'd4);
        step();
        // R2: commit alone clears.
        idle(); wb_we = 1; wb_rd = 5; step();
        idle(); rs2_re = 1; rs2_idx = 5; rs2_rf_data = 64'h55;
        #(CLK_PERIOD/4); check("R2 cleared", 64'(rs2_sel), 64'd0);
        step();
        // R10: flush x6 while issuing x9; x7 survives.
        idle(); iss_valid = 1; iss_rd_we = 1; iss_rd = 6; step();
        idle(); iss_valid = 1; iss_rd_we = 1; iss_rd = 7; step();
        idle(); flush_valid = 1; flush_mask = 32'h0000_0240; iss_valid = 1; iss_rd_we = 1; iss_rd = 9; step();
        idle(); rs1_re = 1; rs1_idx = 6; rs2_re = 1; rs2_idx = 7;
        #(CLK_PERIOD/4);
        check("R10 flushed entry", 64'(rs1_sel), 64'd0);
        check("R10 kept entry", 64'(rs2_sel), 64'd4);
        step();
        idle(); rs1_re = 1; rs1_idx = 9;
        #(CLK_PERIOD/4); check("R10 issue over flush", 64'(rs1_sel), 64'd4);
        step();
        // R4: x0 and disabled reads ignore a matching port.
        idle(); rs1_re = 1; rs1_idx = 0; rs2_re = 0; rs2_idx = 7;
        ex_addr_vld = 1; ex_data_vld = 1; ex_addr = 0; ex_data = 64'hBAD;
        #(CLK_PERIOD/4);
        check("R4 x0 data", rs1_data, 64'd0);
        check("R4 disabled sel", 64'(rs2_sel), 64'd3);
        step();
        // x0 issue never pends (R4).
        idle(); iss_valid = 1; iss_rd_we = 1; iss_rd = 0; step();

        // Random traffic on a narrow index range.
        for (int n = 0; n < 600; n++) begin
            iss_valid   = ($urandom % 3) != 0;
            iss_rd_we   = ($urandom % 4) != 0;
            iss_rd      = IDXW'($urandom % 8);
            wb_we       = ($urandom % 2) != 0;
            wb_rd       = IDXW'($urandom % 8);
            flush_valid = ($urandom % 30) == 0;
            flush_mask  = $urandom;
            rs1_re      = ($urandom % 6) != 0;
            rs2_re      = ($urandom % 6) != 0;
            rs1_idx     = IDXW'($urandom % 8);
            rs2_idx     = IDXW'($urandom % 8);
            rs1_rf_data = {$urandom, $urandom};
            rs2_rf_data = {$urandom, $urandom};
            ex_addr_vld = ($urandom % 3) != 0;
            ex_data_vld = ($urandom % 2) != 0;
            ex_addr     = IDXW'($urandom % 8);
            ex_data     = {$urandom, $urandom};
            ma_addr_vld = ($urandom % 3) != 0;
            ma_data_vld = ($urandom % 3) != 0;
            ma_addr     = IDXW'($urandom % 8);
            ma_data     = {$urandom, $urandom};
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule